// File: doc/BRIEF.md
# Per-Pin Output Source Selector

This block produces the driven value and the driver-off control for each of a bank of I/O pins. Neither is a plain data bit. Each pin owns two configuration words on a simple register bus. One word chooses the pin's output value and the other chooses its enable. In each word a byte-wide select code picks one line out of a wide vector of internal signals, and a separate invert flag can flip the picked line.

Select codes 0 and 1 are reserved as the constants low and high, whatever the vector carries on those two lines. The enable path is active low: an effective 1 turns the pad driver off, so the pin is an input, and an effective 0 makes it drive. Every configuration word can be read back. Both per-pin results are registered, so they follow a write or a change on the picked signal one clock later.

Software directs a pin by writing a select code, and optionally the invert flag, into the pin's words. Byte strobes let the select and the invert flag be written independently.

Top module: `pad_src_sel`

## Requirements
- R1: Pin n (0..63) has its value word at byte address 0x050 + 8·n and its enable word at 0x054 + 8·n. Address bits [1:0] must be zero for a hit.
- R2: A write with strobe bit 0 set loads wdata[7:0] into the select. A write with strobe bit 3 set loads wdata[31] into the invert flag. A field whose strobe is clear keeps its value, and a write with all strobes clear changes nothing.
- R3: A hit read returns {invert, 23 zero bits, select[7:0]}. Bits [30:8] always read zero, and writes to them are dropped.
- R4: Select code 0 yields constant 0 and code 1 yields constant 1 before inversion, independent of sig_vec[0] and sig_vec[1].
- R5: Select codes 2..255 yield sig_vec[code].
- R6: A set invert flag complements the selected value before it reaches the pin.
- R7: pin_oe_n[n] carries the effective enable value of pin n, where 1 means driver off (input) and 0 means drive.
- R8: After reset, every value word reads 0x00000000 and every enable word reads 0x00000001, so all pin_out are 0 and all pin_oe_n are 1.
- R9: pin_out and pin_oe_n are registered. They change one clock edge after the configuration write edge, or after the edge at which a changed selected signal is sampled.
- R10: A read or write at an address that misses (below 0x050, at or above 0x250, or unaligned) returns zero on read and alters no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| sig_vec | input | 256 | Internal signals indexed by select code |
| pin_out | output | 64 | Registered output value per pin |
| pin_oe_n | output | 64 | Registered enable per pin, 1 = driver off |

## Verification
The bench drives sig_vec[0] high and sig_vec[1] low. A design that indexed the raw vector for codes 0 and 1 would then show inverted constants. Partial-strobe writes check that the invert flag survives a select-only write; a design that wrote the whole word would lose it. Writes at unaligned and out-of-window addresses must leave neighbouring words untouched, which a decoder that drops the low bits or the upper range check would fail. The latency test flips the selected signal and samples before and after one edge, which exposes both a missing output register and an extra one.

// File: rtl/pad_sel_pkg.sv
package pad_sel_pkg;
  localparam int SEL_W = 8;

  typedef struct packed {
    logic             inv;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/pad_sel_decode.sv
module pad_sel_decode #(
  parameter int NUM_PINS  = 64,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h50,
  localparam int IDX_W    = $clog2(NUM_PINS),
  localparam int WIN      = NUM_PINS * 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  pin_idx,
  output logic              is_oe
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - ADDR_W'(BASE_ADDR);
    hit     = (addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(WIN)) &&
              (addr[1:0] == 2'b00);
    pin_idx = off[3 +: IDX_W];
    is_oe   = off[2];
  end
endmodule

// File: rtl/pad_sel_cfg_reg.sv
module pad_sel_cfg_reg
  import pad_sel_pkg::*;
#(
  parameter int RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             wr_inv,
  input  logic [SEL_W-1:0] wsel,
  input  logic             winv,
  output cfg_t             cfg
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (wr_sel) cfg_d.sel = wsel;
    if (wr_inv) cfg_d.inv = winv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.sel <= SEL_W'(RST_SEL);
      cfg.inv <= 1'b0;
    end else if (wr_sel || wr_inv) begin
      cfg <= cfg_d;
    end
  end
endmodule

// File: rtl/pad_sel_route.sv
module pad_sel_route
  import pad_sel_pkg::*;
#(
  parameter logic RST_VAL = 1'b0,
  localparam int  NUM_SIG = 2 ** SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SIG-1:0] sig_vec,
  input  cfg_t               cfg,
  output logic               q
);
  logic [NUM_SIG-1:0] sig_fix;
  logic               q_d;

  always_comb begin
    sig_fix = {sig_vec[NUM_SIG-1:2], 2'b10};
    q_d     = sig_fix[cfg.sel] ^ cfg.inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end
endmodule

// File: rtl/pad_src_sel.sv
module pad_src_sel
  import pad_sel_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int BASE_ADDR = 'h50,
  localparam int IDX_W    = $clog2(NUM_PINS),
  localparam int NUM_SIG  = 2 ** SEL_W,
  localparam int BE_W     = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BE_W-1:0]    bus_be,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SIG-1:0] sig_vec,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe_n
);
  logic             hit;
  logic [IDX_W-1:0] pin_idx;
  logic             is_oe;
  cfg_t             out_cfg [NUM_PINS];
  cfg_t             en_cfg  [NUM_PINS];
  cfg_t             rd_cfg;

  pad_sel_decode #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr   (bus_addr),
    .hit    (hit),
    .pin_idx(pin_idx),
    .is_oe  (is_oe)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wr_pin;
    assign wr_pin = bus_we && hit && (pin_idx == IDX_W'(p));

    pad_sel_cfg_reg #(.RST_SEL(0)) u_out_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_sel(wr_pin && !is_oe && bus_be[0]),
      .wr_inv(wr_pin && !is_oe && bus_be[BE_W-1]),
      .wsel  (bus_wdata[SEL_W-1:0]),
      .winv  (bus_wdata[DATA_W-1]),
      .cfg   (out_cfg[p])
    );

    pad_sel_cfg_reg #(.RST_SEL(1)) u_en_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_sel(wr_pin && is_oe && bus_be[0]),
      .wr_inv(wr_pin && is_oe && bus_be[BE_W-1]),
      .wsel  (bus_wdata[SEL_W-1:0]),
      .winv  (bus_wdata[DATA_W-1]),
      .cfg   (en_cfg[p])
    );

    pad_sel_route #(.RST_VAL(1'b0)) u_out_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_vec(sig_vec),
      .cfg    (out_cfg[p]),
      .q      (pin_out[p])
    );

    pad_sel_route #(.RST_VAL(1'b1)) u_en_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_vec(sig_vec),
      .cfg    (en_cfg[p]),
      .q      (pin_oe_n[p])
    );
  end

  always_comb begin
    rd_cfg    = is_oe ? en_cfg[pin_idx] : out_cfg[pin_idx];
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[DATA_W-1]  = rd_cfg.inv;
      bus_rdata[SEL_W-1:0] = rd_cfg.sel;
    end
  end
endmodule

// File: rtl/pad_sel_chk.sv
module pad_sel_chk
  import pad_sel_pkg::*;
#(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  localparam int BE_W    = DATA_W / 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BE_W-1:0]     bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe_n,
  input cfg_t                p0_cfg
);
  logic rst_seen;
  logic wr_p0;
  logic miss;

  always_ff @(posedge clk) rst_seen <= !rst_n;

  assign wr_p0 = bus_we && (bus_addr == ADDR_W'('h50));
  assign miss  = (bus_addr < ADDR_W'('h50)) || (bus_addr >= ADDR_W'('h250)) ||
                 (bus_addr[1:0] != 2'b00);

  // R8: outputs sit at their reset values while reset is held
  always @(posedge clk) begin
    if (!rst_n && rst_seen) begin
      p_reset_pins_r8: assert ((pin_out == '0) && (&pin_oe_n))
        else $error("reset pin state wrong");
    end
  end

  p_wr_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_p0 && bus_be[0]) |=> (p0_cfg.sel == $past(bus_wdata[SEL_W-1:0])));

  p_keep_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_p0 && bus_be[BE_W-1]) |=> $stable(p0_cfg.inv));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-2:SEL_W] == '0);

  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (bus_rdata == '0));

  p_const_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_cfg.sel == '0 && !p0_cfg.inv) |=> !pin_out[0]);

  p_const_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_cfg.sel == SEL_W'(1) && !p0_cfg.inv) |=> pin_out[0]);

  p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_cfg.sel == SEL_W'(1) && p0_cfg.inv) |=> !pin_out[0]);
endmodule

bind pad_src_sel pad_sel_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_be   (bus_be),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_out  (pin_out),
  .pin_oe_n (pin_oe_n),
  .p0_cfg   (out_cfg[0])
);

// File: tb/pad_src_sel_tb.sv
module pad_src_sel_tb;
  logic         clk;
  logic         rst_n;
  logic         bus_we;
  logic [11:0]  bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [255:0] sig_vec;
  logic [63:0]  pin_out;
  logic [63:0]  pin_oe_n;

  int n_chk;
  int n_bad;

  pad_src_sel u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .sig_vec  (sig_vec),
    .pin_out  (pin_out),
    .pin_oe_n (pin_oe_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: addr, be, wdata, expected readback, pin, 0=value/1=enable, expected pin
  localparam int NV = 12;
  localparam logic [87:0] VEC [NV] = '{
    {12'h050, 4'h1, 32'h0000_0003, 32'h0000_0003, 6'd0,  1'b0, 1'b1}, // R1 R5
    {12'h050, 4'h8, 32'h8000_0000, 32'h8000_0003, 6'd0,  1'b0, 1'b0}, // R2 R6
    {12'h050, 4'h1, 32'hFFFF_FF08, 32'h8000_0008, 6'd0,  1'b0, 1'b0}, // R2 keeps inv
    {12'h248, 4'hF, 32'h7FFF_FF0A, 32'h0000_000A, 6'd63, 1'b0, 1'b1}, // R1 R3
    {12'h24C, 4'hF, 32'h0000_0000, 32'h0000_0000, 6'd63, 1'b1, 1'b0}, // R7 drive
    {12'h07C, 4'hF, 32'h8000_0001, 32'h8000_0001, 6'd5,  1'b1, 1'b0}, // R7 R6
    {12'h078, 4'hF, 32'h0000_0001, 32'h0000_0001, 6'd5,  1'b0, 1'b1}, // R4 high
    {12'h078, 4'hF, 32'h8000_0000, 32'h8000_0000, 6'd5,  1'b0, 1'b1}, // R4 R6
    {12'h088, 4'hF, 32'h0000_00FF, 32'h0000_00FF, 6'd7,  1'b0, 1'b0}, // R5 top code
    {12'h088, 4'hF, 32'h8000_00FE, 32'h8000_00FE, 6'd7,  1'b0, 1'b0}, // R5 R6
    {12'h088, 4'hF, 32'h0000_0000, 32'h0000_0000, 6'd7,  1'b0, 1'b0}, // R4 low
    {12'h088, 4'h0, 32'h8000_00FF, 32'h0000_0000, 6'd7,  1'b0, 1'b0}  // R2 no strobes
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 4'h0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    for (int i = 0; i < 256; i++) sig_vec[i] = i[0] ^ i[3];
    sig_vec[0] = 1'b1;
    sig_vec[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 pin_out", {pin_out[31:0]}, 32'h0);
    check("R8 pin_out hi", {pin_out[63:32]}, 32'h0);
    check("R8 pin_oe_n", {pin_oe_n[31:0]}, 32'hFFFF_FFFF);
    check("R8 pin_oe_n hi", {pin_oe_n[63:32]}, 32'hFFFF_FFFF);
    bus_read(12'h054, rd); check("R8 enable word", rd, 32'h1);
    bus_read(12'h050, rd); check("R8 value word", rd, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [87:0] e;
      logic        pv;
      e = VEC[v];
      bus_write(e[87:76], e[75:72], e[71:40]);
      bus_read(e[87:76], rd);
      check($sformatf("R1 R2 R3 readback vec %0d", v), rd, e[39:8]);
      @(negedge clk);
      pv = e[1] ? pin_oe_n[e[7:2]] : pin_out[e[7:2]];
      check($sformatf("R4 R5 R6 R7 pin vec %0d", v), {31'b0, pv}, {31'b0, e[0]});
    end

    // R10 misses
    bus_write(12'h052, 4'hF, 32'h0000_0011);
    bus_read(12'h050, rd); check("R10 unaligned write ignored", rd, 32'h8000_0008);
    bus_read(12'h052, rd); check("R10 unaligned read zero", rd, 32'h0);
    bus_write(12'h250, 4'hF, 32'h8000_0022);
    bus_read(12'h250, rd); check("R10 above window read zero", rd, 32'h0);
    bus_read(12'h24C, rd); check("R10 last word intact", rd, 32'h0);
    bus_write(12'h04C, 4'hF, 32'h8000_0033);
    bus_read(12'h04C, rd); check("R10 below window read zero", rd, 32'h0);

    // R9 latency: pin 0 value picks signal 9 (pattern value 0)
    bus_write(12'h050, 4'hF, 32'h0000_0009);
    @(negedge clk);
    check("R5 sel 9 before flip", {31'b0, pin_out[0]}, 32'h0);
    sig_vec[9] = 1'b1;
    #1;
    check("R9 no combinational path", {31'b0, pin_out[0]}, 32'h0);
    @(negedge clk);
    check("R9 one edge later", {31'b0, pin_out[0]}, 32'h1);
    bus_write(12'h050, 4'h8, 32'h8000_0000);
    check("R9 unchanged at write edge", {31'b0, pin_out[0]}, 32'h1);
    @(negedge clk);
    check("R6 R9 inverted after edge", {31'b0, pin_out[0]}, 32'h0);

    finish_run();
  end
endmodule